// File: doc/BRIEF.md
# Byte FIFO with Direction-Dependent Transfer Request Triggers

The block is a byte-wide data buffer that sits between a flash-memory data path and a host bus. The flash side moves one byte per cycle. The host side moves one 32-bit word (four bytes) per cycle. A direction input selects the active mode. In read mode the flash side fills the buffer and the host drains it. In write mode the host fills the buffer and the flash side drains it.

Two level outputs tell the host when to move data: a CPU interrupt request and a DMA transfer request. A 2-bit trigger field in a control register selects their thresholds. In read mode the thresholds apply to the number of bytes held. In write mode they apply to the number of bytes free. The two requests can use different thresholds, and in two of the write-mode settings the DMA request is never raised.

The same control register holds a clear bit for a small auxiliary address counter. The counter advances on a step input. It is forced to zero while the clear bit is 1.

Top module: `fifo_trig_ctl`

## Requirements
- R1: After reset the control register reads 0 (trigger 00, clear bit 0), the buffer is empty, the auxiliary counter is 0, and in read mode (dir_i = 0) both requests are low.
- R2: The trigger field is control bits 21:20 and the clear bit is bit 19. All other bits (31:22 and 18:0) always read 0, whatever value is written to them.
- R3: In read mode, trigger 00, 01 and 10 raise both irq_o and dma_req_o when at least 4, 16 or 128 bytes are held, respectively.
- R4: In read mode, trigger 11 raises irq_o when 128 bytes are held and dma_req_o when at least 16 bytes are held.
- R5: In write mode (dir_i = 1), trigger 00 raises irq_o when at least 4 bytes are free, and trigger 10 raises irq_o when 128 bytes are free. With either setting dma_req_o stays low.
- R6: In write mode, trigger 01 raises both requests when at least 16 bytes are free. Trigger 11 raises irq_o when 128 bytes are free and dma_req_o when at least 16 bytes are free.
- R7: Data leaves in the order it entered. A host word carries the earliest byte in bits 7:0 and the latest in bits 31:24. host_rdata_o and flash_rdata_o show the oldest data without a pop.
- R8: A host word write needs at least 4 free bytes and write mode. A host word read needs at least 4 held bytes and read mode. A flash byte write needs 1 free byte and read mode. A flash byte read needs 1 held byte and write mode. Any other access is ignored and changes nothing.
- R9: The requests are levels. They follow the occupancy in the cycle after each accepted access, and they follow a new trigger or direction in the cycle after it is written or driven.
- R10: aux_cnt_o counts aux_step_i pulses. While the clear bit is 1 the counter is held at 0 and steps are ignored. Once the bit returns to 0, counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | 0 = read mode (flash fills, host drains), 1 = write mode (host fills, flash drains) |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| ctrl_rdata_o | output | 32 | Control register read value |
| host_wr_i | input | 1 | Host word write |
| host_wdata_i | input | 32 | Host write word, earliest byte in bits 7:0 |
| host_rd_i | input | 1 | Host word read (pop) |
| host_rdata_o | output | 32 | Oldest four bytes in the buffer |
| flash_wr_i | input | 1 | Flash byte write |
| flash_wdata_i | input | 8 | Flash write byte |
| flash_rd_i | input | 1 | Flash byte read (pop) |
| flash_rdata_o | output | 8 | Oldest byte in the buffer |
| aux_step_i | input | 1 | Auxiliary counter advance |
| aux_cnt_o | output | 8 | Auxiliary counter value |
| irq_o | output | 1 | CPU interrupt request (level) |
| dma_req_o | output | 1 | DMA transfer request (level) |

## Verification
The assertions assume that software never leaves the clear bit set across normal counter use. They also assume that the trigger field holds only the four defined codes, which a 2-bit field guarantees. They do not assume that accesses are legal: overflow and underflow attempts must be absorbed by the buffer itself. The stimulus changes direction only when the buffer is empty or at a chosen fill level. It sweeps every fill level from empty to full and back for each trigger code in both directions, and it deliberately issues over-full, under-filled and wrong-direction accesses.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW   = 2'b00,
    TRIG_MID   = 2'b01,
    TRIG_HIGH  = 2'b10,
    TRIG_SPLIT = 2'b11
  } trig_e;

  localparam int unsigned TRIG_LSB = 20;
  localparam int unsigned CLR_BIT  = 19;
endpackage

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int unsigned AUX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic             aux_step_i,
  output trig_e            trig_o,
  output logic [31:0]      rdata_o,
  output logic [AUX_W-1:0] aux_cnt_o
);
  trig_e            trig_q;
  logic             clr_q;
  logic [AUX_W-1:0] aux_q;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata_i[31:TRIG_LSB+2], wdata_i[CLR_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= TRIG_LOW;
      clr_q  <= 1'b0;
    end else if (we_i) begin
      trig_q <= trig_e'(wdata_i[TRIG_LSB +: 2]);
      clr_q  <= wdata_i[CLR_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         aux_q <= '0;
    else if (clr_q)      aux_q <= '0;
    else if (aux_step_i) aux_q <= aux_q + AUX_W'(1);
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[TRIG_LSB +: 2]   = trig_q;
    rdata_o[CLR_BIT]         = clr_q;
  end

  assign trig_o    = trig_q;
  assign aux_cnt_o = aux_q;

  // R10: clear bit forces the counter to zero
  a_r10_aux_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> (aux_q == '0));
  // R10: no step, no clear -> counter holds
  a_r10_aux_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_q && !aux_step_i) |=> $stable(aux_q));
endmodule

// File: rtl/fifo_trig_buf.sv
module fifo_trig_buf #(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned PW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned HWW = 8 * WORD_BYTES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_dir_i,
  input  logic           host_wr_i,
  input  logic [HWW-1:0] host_wdata_i,
  input  logic           host_rd_i,
  output logic [HWW-1:0] host_rdata_o,
  input  logic           flash_wr_i,
  input  logic [7:0]     flash_wdata_i,
  input  logic           flash_rd_i,
  output logic [7:0]     flash_rdata_o,
  output logic [CW-1:0]  count_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, free_w, push_n, pop_n;
  logic          host_push, host_pop, flash_push, flash_pop;

  assign free_w     = CW'(DEPTH) - count_q;
  assign host_push  =  wr_dir_i && host_wr_i  && (free_w  >= CW'(WORD_BYTES));
  assign flash_pop  =  wr_dir_i && flash_rd_i && (count_q != '0);
  assign flash_push = !wr_dir_i && flash_wr_i && (free_w  != '0);
  assign host_pop   = !wr_dir_i && host_rd_i  && (count_q >= CW'(WORD_BYTES));

  assign push_n = host_push ? CW'(WORD_BYTES) : (flash_push ? CW'(1) : '0);
  assign pop_n  = host_pop  ? CW'(WORD_BYTES) : (flash_pop  ? CW'(1) : '0);

  always_ff @(posedge clk_i) begin
    if (host_push) begin
      for (int i = 0; i < WORD_BYTES; i++)
        mem[wr_ptr_q + PW'(i)] <= host_wdata_i[8*i +: 8];
    end else if (flash_push) begin
      mem[wr_ptr_q] <= flash_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PW'(push_n);
      rd_ptr_q <= rd_ptr_q + PW'(pop_n);
      count_q  <= count_q + push_n - pop_n;
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_hrd
    assign host_rdata_o[8*g +: 8] = mem[rd_ptr_q + PW'(g)];
  end
  assign flash_rdata_o = mem[rd_ptr_q];
  assign count_o       = count_q;

  // R8: occupancy never exceeds the depth
  always_comb begin
    if (rst_ni) a_r8_no_overflow: assert (count_q <= CW'(DEPTH));
  end
  // R8: a full buffer stays full until something is popped
  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH) && pop_n == '0) |=> (count_q == CW'(DEPTH)));
  // R8: an empty buffer stays empty until something is pushed
  a_r8_empty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && push_n == '0) |=> (count_q == '0));
endmodule

// File: rtl/fifo_trig_req.sv
module fifo_trig_req
  import fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned TH_SMALL = 4,
  parameter int unsigned TH_MID   = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_dir_i,
  input  trig_e         trig_i,
  input  logic [CW-1:0] count_i,
  output logic          irq_o,
  output logic          dma_o
);
  localparam logic [CW-1:0] T_S = CW'(TH_SMALL);
  localparam logic [CW-1:0] T_M = CW'(TH_MID);
  localparam logic [CW-1:0] T_B = CW'(DEPTH);

  logic [CW-1:0] lvl;

  // read mode measures held bytes, write mode measures free bytes
  assign lvl = wr_dir_i ? (T_B - count_i) : count_i;

  always_comb begin
    irq_o = 1'b0;
    dma_o = 1'b0;
    unique case (trig_i)
      TRIG_LOW: begin
        irq_o = lvl >= T_S;
        dma_o = !wr_dir_i && (lvl >= T_S);
      end
      TRIG_MID: begin
        irq_o = lvl >= T_M;
        dma_o = lvl >= T_M;
      end
      TRIG_HIGH: begin
        irq_o = lvl >= T_B;
        dma_o = !wr_dir_i && (lvl >= T_B);
      end
      TRIG_SPLIT: begin
        irq_o = lvl >= T_B;
        dma_o = lvl >= T_M;
      end
      default: ;
    endcase
  end

  // R4: split setting in read mode: interrupt implies DMA request
  a_r4_split_read_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_dir_i && trig_i == TRIG_SPLIT && irq_o) |-> dma_o);
  // R6: split setting in write mode: interrupt implies DMA request
  a_r6_split_write_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dir_i && trig_i == TRIG_SPLIT && irq_o) |-> dma_o);
  // R3: full buffer in read mode always raises both requests
  a_r3_full_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_dir_i && count_i == T_B) |-> (irq_o && dma_o));
  // R5: empty buffer in write mode raises the interrupt for 00 and 10
  a_r5_empty_write_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dir_i && count_i == '0 && (trig_i == TRIG_LOW || trig_i == TRIG_HIGH))
      |-> (irq_o && !dma_o));
endmodule

// File: rtl/fifo_trig_ctl.sv
module fifo_trig_ctl
  import fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned TH_SMALL   = 4,
  parameter int unsigned TH_MID     = 16,
  parameter int unsigned AUX_W      = 8,
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned HWW = 8 * WORD_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  output logic [31:0]      ctrl_rdata_o,
  input  logic             host_wr_i,
  input  logic [HWW-1:0]   host_wdata_i,
  input  logic             host_rd_i,
  output logic [HWW-1:0]   host_rdata_o,
  input  logic             flash_wr_i,
  input  logic [7:0]       flash_wdata_i,
  input  logic             flash_rd_i,
  output logic [7:0]       flash_rdata_o,
  input  logic             aux_step_i,
  output logic [AUX_W-1:0] aux_cnt_o,
  output logic             irq_o,
  output logic             dma_req_o
);
  trig_e         trig_w;
  logic          dir_q;
  logic [CW-1:0] count_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_i;
  end

  fifo_trig_ctrl #(.AUX_W(AUX_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .aux_step_i (aux_step_i),
    .trig_o     (trig_w),
    .rdata_o    (ctrl_rdata_o),
    .aux_cnt_o  (aux_cnt_o)
  );

  fifo_trig_buf #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) buf_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_dir_i      (dir_q),
    .host_wr_i     (host_wr_i),
    .host_wdata_i  (host_wdata_i),
    .host_rd_i     (host_rd_i),
    .host_rdata_o  (host_rdata_o),
    .flash_wr_i    (flash_wr_i),
    .flash_wdata_i (flash_wdata_i),
    .flash_rd_i    (flash_rd_i),
    .flash_rdata_o (flash_rdata_o),
    .count_o       (count_w)
  );

  fifo_trig_req #(.DEPTH(DEPTH), .TH_SMALL(TH_SMALL), .TH_MID(TH_MID)) req_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_dir_i (dir_q),
    .trig_i   (trig_w),
    .count_i  (count_w),
    .irq_o    (irq_o),
    .dma_o    (dma_req_o)
  );
endmodule

// File: tb/fifo_trig_ctl_tb_top.sv
module fifo_trig_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_rdata_o;
  logic        host_wr_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic        host_rd_i = 1'b0;
  logic [31:0] host_rdata_o;
  logic        flash_wr_i = 1'b0;
  logic [7:0]  flash_wdata_i = '0;
  logic        flash_rd_i = 1'b0;
  logic [7:0]  flash_rdata_o;
  logic        aux_step_i = 1'b0;
  logic [7:0]  aux_cnt_o;
  logic        irq_o, dma_req_o;

  int checks = 0;
  int errors = 0;
  int mc = 0;      // model occupancy
  int mdir = 0;
  int mtrig = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_trig_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dir_i(dir_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
    .flash_wr_i(flash_wr_i), .flash_wdata_i(flash_wdata_i),
    .flash_rd_i(flash_rd_i), .flash_rdata_o(flash_rdata_o),
    .aux_step_i(aux_step_i), .aux_cnt_o(aux_cnt_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (dir %0d trig %0d fill %0d)",
               req, act, exp, mdir, mtrig, mc);
    end
  endtask

  function automatic bit exp_irq(int d, int t, int c);
    int fr = 128 - c;
    if (d == 0) return (t == 0) ? c >= 4 : (t == 1) ? c >= 16 : c >= 128;
    return (t == 0) ? fr >= 4 : (t == 1) ? fr >= 16 : fr >= 128;
  endfunction

  function automatic bit exp_dma(int d, int t, int c);
    int fr = 128 - c;
    if (d == 0) return (t == 0) ? c >= 4 : (t == 2) ? c >= 128 : c >= 16;
    return (t == 1 || t == 3) ? fr >= 16 : 1'b0;
  endfunction

  task automatic check_req();
    string tag;
    if (mdir == 0) tag = (mtrig == 3) ? "R4" : "R3";
    else           tag = (mtrig == 0 || mtrig == 2) ? "R5" : "R6";
    check({tag, " irq"}, 32'(irq_o), 32'(exp_irq(mdir, mtrig, mc)));
    check({tag, " dma"}, 32'(dma_req_o), 32'(exp_dma(mdir, mtrig, mc)));
  endtask

  task automatic ctrl_wr(input logic [31:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk);
    ctrl_we_i = 1'b0;
  endtask

  task automatic set_trig(input int t);
    ctrl_wr(32'(t) << 20);
    mtrig = t;
  endtask

  task automatic set_dir(input int d);
    dir_i = d[0];
    @(negedge clk);
    mdir = d;
  endtask

  task automatic fl_push(input logic [7:0] b);
    flash_wr_i = 1'b1; flash_wdata_i = b;
    @(negedge clk);
    flash_wr_i = 1'b0;
  endtask

  task automatic fl_pop();
    flash_rd_i = 1'b1;
    @(negedge clk);
    flash_rd_i = 1'b0;
  endtask

  task automatic h_push(input logic [31:0] w);
    host_wr_i = 1'b1; host_wdata_i = w;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic h_pop();
    host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
  endtask

  function automatic logic [7:0] rv(int t, int k);
    return 8'((k * 5 + t * 17 + 1) & 255);
  endfunction

  function automatic logic [7:0] wv(int t, int k);
    return 8'((k * 11 + t * 29 + 3) & 255);
  endfunction

  task automatic sweep_read(input int t);
    set_dir(0);
    set_trig(t);
    check_req();
    for (int k = 0; k < 128; k++) begin
      fl_push(rv(t, k)); mc++;
      check_req();
    end
    // R8: flash write when full is ignored
    fl_push(8'hEE);
    check_req();
    for (int w = 0; w < 32; w++) begin
      check("R7 host word", host_rdata_o,
            {rv(t, 4*w+3), rv(t, 4*w+2), rv(t, 4*w+1), rv(t, 4*w)});
      h_pop(); mc -= 4;
      check_req();
    end
  endtask

  task automatic sweep_write(input int t);
    set_dir(1);
    set_trig(t);
    check_req();
    for (int w = 0; w < 32; w++) begin
      h_push({wv(t, 4*w+3), wv(t, 4*w+2), wv(t, 4*w+1), wv(t, 4*w)}); mc += 4;
      check_req();
    end
    // R8: host write when full is ignored
    h_push(32'hDEAD_BEEF);
    check_req();
    for (int k = 0; k < 128; k++) begin
      check("R7 flash byte", 32'(flash_rdata_o), 32'(wv(t, k)));
      fl_pop(); mc--;
      check_req();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ctrl", ctrl_rdata_o, 32'h0);
    check("R1 aux", 32'(aux_cnt_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 dma", 32'(dma_req_o), 32'h0);

    // R2 field layout and reserved bits
    ctrl_wr(32'hFFFF_FFFF);
    check("R2 all ones", ctrl_rdata_o, 32'h0038_0000);
    ctrl_wr(32'h0020_0000);
    check("R2 trig 10", ctrl_rdata_o, 32'h0020_0000);
    ctrl_wr(32'hFFC7_FFFF);
    check("R2 reserved only", ctrl_rdata_o, 32'h0);

    // R3..R7 full sweeps
    for (int t = 0; t < 4; t++) sweep_read(t);
    for (int t = 0; t < 4; t++) sweep_write(t);

    // R8 wrong-direction and short accesses
    set_dir(0); set_trig(0);
    h_push(32'h1111_1111);              // host write in read mode
    check_req();
    check("R8 wrong dir host write", 32'(dma_req_o), 32'h0);
    fl_pop();                            // flash read in read mode
    fl_push(8'hA0); fl_push(8'hA1); mc = 2;
    h_pop();                             // only 2 held
    check_req();
    fl_push(8'hA2); fl_push(8'hA3); mc = 4;
    check_req();
    check("R8 short pop ignored", host_rdata_o, 32'hA3A2_A1A0);
    h_pop(); mc = 0;
    check_req();
    set_dir(1);
    fl_pop();                            // empty, ignored
    h_push(32'h4433_2211); mc = 4;
    check("R8 empty flash pop ignored", 32'(flash_rdata_o), 32'h11);
    for (int k = 0; k < 4; k++) begin fl_pop(); mc--; end
    check_req();

    // R9 re-evaluation after trigger and direction changes
    set_dir(0);
    for (int k = 0; k < 16; k++) begin fl_push(8'(k)); mc++; end
    check("R9 dma at 16 trig 00", 32'(dma_req_o), 32'h1);
    set_trig(2);
    check("R9 dma after trig 10", 32'(dma_req_o), 32'h0);
    set_dir(1);
    check_req();
    check("R9 dir write trig 10 irq", 32'(irq_o), 32'h0);
    set_trig(1);
    check("R9 dir write trig 01 dma", 32'(dma_req_o), 32'h1);
    set_dir(0);
    check_req();
    for (int w = 0; w < 4; w++) begin h_pop(); mc -= 4; end
    check("R9 drained read trig 01 dma", 32'(dma_req_o), 32'h0);

    // R10 auxiliary counter
    aux_step_i = 1'b1;
    repeat (5) @(negedge clk);
    aux_step_i = 1'b0;
    check("R10 count", 32'(aux_cnt_o), 32'd5);
    ctrl_wr(32'h0018_0000);
    aux_step_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 held at zero", 32'(aux_cnt_o), 32'd0);
    aux_step_i = 1'b0;
    ctrl_wr(32'h0010_0000);
    check("R10 still zero", 32'(aux_cnt_o), 32'd0);
    check("R2 clear bit dropped", ctrl_rdata_o, 32'h0010_0000);
    aux_step_i = 1'b1;
    repeat (3) @(negedge clk);
    aux_step_i = 1'b0;
    check("R10 resumes from zero", 32'(aux_cnt_o), 32'd3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule